// File: doc/BRIEF.md
# Edge Interrupt and Wakeup Detector

This block watches the already-synchronized levels of a bank of general-purpose pins and turns their transitions into two kinds of event. Each pin has its own rising and falling enables for the interrupt path. Each pin also has a second, independent pair of rising and falling enables for the wakeup path. An enabled interrupt edge latches a per-pin interrupt status bit. An enabled wakeup edge latches a per-pin wakeup status bit, but only on pins whose sleep-control input is low. Software clears either status vector by writing ones to a clear selector. The block drives one combined interrupt line and one combined wakeup line.

All configuration goes through one write port. `wr_sel` picks the target and `wr_data` carries a full pin-wide vector. Only edges are detected: a pin counts as having an edge when its present level differs from the level it had at the previous clock edge. A pin held at a steady level, high or low, never raises an event.

A two-state machine gates detection. `ST_PRIME` is entered on reset. It captures the pin levels once and raises no events. It moves unconditionally to `ST_LIVE` on the first clock after reset (transition PRIME→LIVE). `ST_LIVE` compares each level against the captured one and holds itself (transition LIVE→LIVE) until the next reset. Because of this, the reset value of the level register can never look like an edge.

Top module: `gpio_edge_wake`

## Requirements
- R1: After reset, all four enable masks and both status vectors are zero, and `irq_o` and `wake_o` are low.
- R2: A 0→1 change of a pin whose interrupt-rising enable is set (`wr_sel`=0) sets that pin's `irq_status` bit, visible one clock after the clock edge at which the new level is sampled.
- R3: A 1→0 change of a pin whose interrupt-falling enable is set (`wr_sel`=1) sets that pin's `irq_status` bit. A pin with both enables set latches on either direction.
- R4: Edges on pins whose enable for that direction is clear leave their status bits unchanged.
- R5: Writing with `wr_sel`=4 clears every `irq_status` bit whose `wr_data` bit is 1. Bits written as 0 keep their value. Status bits otherwise never fall.
- R6: When an enabled edge and a clear of the same bit arrive at the same clock edge, the bit ends up set.
- R7: `irq_o` is high exactly when at least one `irq_status` bit is set.
- R8: The wakeup-rising (`wr_sel`=2) and wakeup-falling (`wr_sel`=3) enables act only on `wake_status`, and the interrupt enables act only on `irq_status`.
- R9: A wakeup edge is latched only on pins whose `sleep_ctl` bit is 0. A 1 blocks wakeup for that pin and leaves its interrupt path untouched.
- R10: Writing with `wr_sel`=5 clears the `wake_status` bits named by ones in `wr_data`. `wake_o` is high exactly when some `wake_status` bit is set.
- R11: A pin held at a constant level, high or low, for any number of cycles sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | N_PINS | Synchronized pin levels |
| sleep_ctl | input | N_PINS | Per-pin wakeup gate, 0 = wakeup allowed |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 irq rise, 1 irq fall, 2 wake rise, 3 wake fall, 4 irq clear, 5 wake clear; 6 and 7 ignored |
| wr_data | input | N_PINS | Mask value or clear vector |
| irq_status | output | N_PINS | Latched interrupt status per pin |
| wake_status | output | N_PINS | Latched wakeup status per pin |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wakeup request |

## Verification
A corrupted enable mask or a wrong captured level shows up one cycle after the next transition on the affected pin. The pin's status bit either appears when it should not or fails to appear, so the bench compares both status vectors and both combined lines after every clock against a reference model. A status register that drops or gains bits on its own is caught at the very next clock by the checker. The checker requires every newly set bit to have a level change behind it and every dropped bit to have a clear behind it. A faulty sleep gate is visible on the first wakeup edge of a sleeping pin.

// File: rtl/gped_pkg.sv
`timescale 1ns/1ps
package gped_pkg;

    typedef enum logic [2:0] {
        SEL_IRQ_RISE  = 3'd0,
        SEL_IRQ_FALL  = 3'd1,
        SEL_WAKE_RISE = 3'd2,
        SEL_WAKE_FALL = 3'd3,
        SEL_IRQ_CLR   = 3'd4,
        SEL_WAKE_CLR  = 3'd5
    } wsel_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_LIVE  = 1'b1
    } det_state_e;

    localparam int NUM_MASKS = 4;

endpackage

// File: rtl/gped_edge_sense.sv
`timescale 1ns/1ps
module gped_edge_sense
    import gped_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_lvl,
    output logic [N_PINS-1:0] rise_v,
    output logic [N_PINS-1:0] fall_v
);

    det_state_e        state_q;
    det_state_e        state_d;
    logic [N_PINS-1:0] prev_q;
    logic              live;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_LIVE;
            ST_LIVE:  state_d = ST_LIVE;
            default:  state_d = ST_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        live = 1'b0;
        unique case (state_q)
            ST_PRIME: live = 1'b0;
            ST_LIVE:  live = 1'b1;
            default:  live = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_lvl;
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        assign rise_v[g] = live &  pin_lvl[g] & ~prev_q[g];
        assign fall_v[g] = live & ~pin_lvl[g] &  prev_q[g];
    end

endmodule

// File: rtl/gped_masks.sv
`timescale 1ns/1ps
module gped_masks
    import gped_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] irq_rise_m,
    output logic [N_PINS-1:0] irq_fall_m,
    output logic [N_PINS-1:0] wake_rise_m,
    output logic [N_PINS-1:0] wake_fall_m
);

    logic [N_PINS-1:0] mask_q [NUM_MASKS];

    // mask index k is written by selector value k (0..3)
    for (genvar k = 0; k < NUM_MASKS; k++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[k] <= '0;
            else if (wr_en && (wr_sel == 3'(k)))
                mask_q[k] <= wr_data;
        end
    end

    assign irq_rise_m  = mask_q[SEL_IRQ_RISE];
    assign irq_fall_m  = mask_q[SEL_IRQ_FALL];
    assign wake_rise_m = mask_q[SEL_WAKE_RISE];
    assign wake_fall_m = mask_q[SEL_WAKE_FALL];

endmodule

// File: rtl/gped_sticky.sv
`timescale 1ns/1ps
module gped_sticky #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] set_v,
    input  logic [N_PINS-1:0] clr_v,
    output logic [N_PINS-1:0] status,
    output logic              any
);

    logic [N_PINS-1:0] stat_q;

    // a new event outranks a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_v) | set_v;
    end

    assign status = stat_q;
    assign any    = |stat_q;

endmodule

// File: rtl/gpio_edge_wake.sv
`timescale 1ns/1ps
module gpio_edge_wake
    import gped_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_lvl,
    input  logic [N_PINS-1:0] sleep_ctl,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] irq_status,
    output logic [N_PINS-1:0] wake_status,
    output logic              irq_o,
    output logic              wake_o
);

    logic [N_PINS-1:0] rise_v, fall_v;
    logic [N_PINS-1:0] irq_rise_m, irq_fall_m, wake_rise_m, wake_fall_m;
    logic [N_PINS-1:0] irq_ev, wake_ev, irq_clr, wake_clr;

    gped_edge_sense #(.N_PINS(N_PINS)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .rise_v  (rise_v),
        .fall_v  (fall_v)
    );

    gped_masks #(.N_PINS(N_PINS)) u_masks (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .irq_rise_m  (irq_rise_m),
        .irq_fall_m  (irq_fall_m),
        .wake_rise_m (wake_rise_m),
        .wake_fall_m (wake_fall_m)
    );

    always_comb begin
        irq_ev   = (rise_v & irq_rise_m) | (fall_v & irq_fall_m);
        wake_ev  = ((rise_v & wake_rise_m) | (fall_v & wake_fall_m)) & ~sleep_ctl;
        irq_clr  = (wr_en && wr_sel == SEL_IRQ_CLR)  ? wr_data : '0;
        wake_clr = (wr_en && wr_sel == SEL_WAKE_CLR) ? wr_data : '0;
    end

    gped_sticky #(.N_PINS(N_PINS)) u_irq_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (irq_ev),
        .clr_v  (irq_clr),
        .status (irq_status),
        .any    (irq_o)
    );

    gped_sticky #(.N_PINS(N_PINS)) u_wake_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (wake_ev),
        .clr_v  (wake_clr),
        .status (wake_status),
        .any    (wake_o)
    );

endmodule

// File: rtl/gpio_edge_wake_chk.sv
`timescale 1ns/1ps
module gpio_edge_wake_chk #(
    parameter int N_PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] pin_lvl,
    input logic [N_PINS-1:0] sleep_ctl,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [N_PINS-1:0] wr_data,
    input logic [N_PINS-1:0] irq_status,
    input logic [N_PINS-1:0] wake_status,
    input logic              irq_o,
    input logic              wake_o
);

    a_r11_set_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_status & ~$past(irq_status)) & ~($past(pin_lvl) ^ $past(pin_lvl, 2))) == '0);

    a_r5_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq_status) & ~irq_status) &
         ~(($past(wr_en) && $past(wr_sel) == 3'd4) ? $past(wr_data) : '0)) == '0);

    a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_status & ~$past(wake_status)) & $past(sleep_ctl)) == '0);

    a_r10_wake_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_o) |-> ($past(wr_en) && $past(wr_sel) == 3'd5));

    a_r7_irq_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(pin_lvl) != $past(pin_lvl, 2)));

endmodule

bind gpio_edge_wake gpio_edge_wake_chk #(.N_PINS(N_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_lvl     (pin_lvl),
    .sleep_ctl   (sleep_ctl),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .irq_status  (irq_status),
    .wake_status (wake_status),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/sim_gpio_edge_wake.sv
`timescale 1ns/1ps
module sim_gpio_edge_wake;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_lvl = '0, sleep_ctl = '0, wr_data = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [N-1:0] irq_status, wake_status;
    logic         irq_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] m_ir, m_if, m_wr, m_wf, m_is, m_ws, m_prev;
    bit           m_live;

    always #2 clk = ~clk;

    gpio_edge_wake #(.N_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .sleep_ctl(sleep_ctl),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_status(irq_status), .wake_status(wake_status),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [N-1:0] clr_of(bit e, logic [2:0] s, logic [N-1:0] d, logic [2:0] want);
        return (e && s == want) ? d : '0;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (irq_status !== m_is || wake_status !== m_ws ||
            irq_o !== (|m_is) || wake_o !== (|m_ws)) begin
            errors++;
            $display("FAIL %s: irq %h/%b wake %h/%b expected irq %h/%b wake %h/%b",
                     tag, irq_status, irq_o, wake_status, wake_o,
                     m_is, |m_is, m_ws, |m_ws);
        end
    endtask

    // drive one cycle at a falling edge, update the model, compare a cycle later
    task automatic tick(input logic [N-1:0] p, input logic [N-1:0] s, input bit e,
                        input logic [2:0] sl, input logic [N-1:0] d, input string tag);
        logic [N-1:0] rise, fall;
        pin_lvl = p; sleep_ctl = s; wr_en = e; wr_sel = sl; wr_data = d;
        rise = m_live ? (p & ~m_prev) : '0;
        fall = m_live ? (~p & m_prev) : '0;
        m_is = (m_is & ~clr_of(e, sl, d, 3'd4)) | (rise & m_ir) | (fall & m_if);
        m_ws = (m_ws & ~clr_of(e, sl, d, 3'd5)) | (((rise & m_wr) | (fall & m_wf)) & ~s);
        if (e && sl == 3'd0) m_ir = d;
        if (e && sl == 3'd1) m_if = d;
        if (e && sl == 3'd2) m_wr = d;
        if (e && sl == 3'd3) m_wf = d;
        m_prev = p;
        m_live = 1;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        logic [N-1:0] p;
        void'($urandom(32'h5eed_0042));
        m_ir = '0; m_if = '0; m_wr = '0; m_wf = '0; m_is = '0; m_ws = '0;
        m_prev = '0; m_live = 0;
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        check("R1 after reset");
        tick('0, '0, 0, 0, '0, "R1 prime");

        // interrupt masks: pins 0,1 both edges, 4-7 rise only, 8-11 fall only
        tick('0, '0, 1, 0, 32'h0000_00F3, "R1 mask write");
        tick('0, '0, 1, 1, 32'h0000_0F03, "R1 mask write");
        tick(32'h0000_FFFF, '0, 0, 0, '0, "R2 R4 rise");
        if (m_is !== 32'h0000_00F3) begin errors++; $display("FAIL R2 model %h expected %h", m_is, 32'h0000_00F3); end
        checks++;
        tick(32'h0000_FFFF, '0, 0, 0, '0, "R11 hold high");
        tick(32'h0000_FFFF, '0, 0, 0, '0, "R11 hold high");
        tick(32'h0000_FFFF, '0, 1, 4, 32'h0000_0003, "R5 partial clear");
        tick(32'h0000_FFFF, '0, 1, 6, 32'hFFFF_FFFF, "R5 unused selector");
        tick('0, '0, 0, 0, '0, "R3 R4 fall");
        tick('0, '0, 0, 0, '0, "R11 hold low");
        tick(32'h0000_0010, '0, 1, 4, 32'h0000_0030, "R6 edge beats clear");
        tick(32'h0000_0010, '0, 1, 4, 32'hFFFF_FFFF, "R7 all cleared");
        tick(32'h0000_0010, '0, 0, 0, '0, "R7 stays low");

        // wakeup masks: rise on 24-31, fall on 16-23
        tick(32'h0000_0010, '0, 1, 2, 32'hFF00_0000, "R8 wake mask");
        tick(32'h0000_0010, '0, 1, 3, 32'h00FF_0000, "R8 wake mask");
        tick(32'hFFFF_0010, '0, 0, 0, '0, "R8 wake rise only");
        tick(32'hFFFF_0010, '0, 1, 5, 32'hFFFF_FFFF, "R10 wake clear");
        tick(32'h0000_0010, 32'h000F_0000, 0, 0, '0, "R9 sleep gate");
        tick(32'hFFFF_0010, 32'hF000_0000, 0, 0, '0, "R9 sleep gate rise");
        tick(32'hFFFF_0010, '0, 1, 5, 32'h0F00_0000, "R10 partial wake clear");
        tick(32'hFFFF_0010, '0, 1, 5, 32'hFFFF_FFFF, "R10 wake clear all");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit e;
            logic [2:0] sl;
            p = pin_lvl ^ ($urandom() & $urandom());
            e = ($urandom_range(0, 3) == 0);
            sl = 3'($urandom_range(0, 7));
            tick(p, $urandom() & $urandom(), e, sl, $urandom(), "R2 R3 R8 R9 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule